// File: doc/BRIEF.md
# Edge-Activated DMA Request Acceptor

This block sits between an active-low external DMA request pin and one channel of a DMA controller. It turns activity on the pin into a single held-request flag that the controller consumes. In edge mode, one falling edge on the pin yields at most one single-address transfer. After the controller starts the transfer, the block will not take another request until two things have happened: the pin has been seen high again, and the current single transfer cycle has ended. A programmable floor on the number of non-accepting cycles after activation is applied on top of this.

The pin goes through a synchronizer before it is examined. Acceptance begins only after an enable strobe, which marks the end of the register write that turns the channel on. A transfer-end input returns the block to idle at any time. With the mode bit at 0, the block works on levels instead: a low pin raises a request whenever the block is accepting, and no high level is needed to re-arm it.

The controller samples `req_held` to decide whether to start a transfer. It pulses `activate` when the transfer begins, `cycle_end` when the single cycle completes, and `xfer_end` when the whole transfer is over.

Top module: `dma_req_accept`

## Requirements
- R1: After reset the block is idle (state code 0) and ignores the pin. A one-cycle `en_strobe` in idle makes `accepting` high (state code 1) on the next rising edge.
- R2: The pin passes through SYNC_STAGES flops (default 2). A low level driven before rising edge 1 and held makes `req_held` high (state code 2) after rising edge 3. After edges 1 and 2 the block is still accepting.
- R3: `req_held` stays high until `activate` is sampled high, and is low after that same edge.
- R4: In edge mode (`edge_mode`=1), activation moves the block to waiting-for-high (state code 3). While the pin stays low, the block does not accept, whether or not the cycle has ended.
- R5: If a synchronized high has been seen but the single cycle has not ended, the block waits in state code 4. It becomes accepting on the edge that samples `cycle_end`, provided the clear floor has elapsed.
- R6: If `cycle_end` arrives before any high, the block stays in state code 3. It becomes accepting on the edge that samples the synchronized high.
- R7: After activation the block spends at least MIN_CLEAR (default 2) cycles non-accepting, even when the high and the cycle end are both already present.
- R8: In level mode (`edge_mode`=0), activation goes directly to state code 4. Once the cycle has ended and the clear floor has passed, the block accepts, and a pin that is still low raises a new request on the next edge.
- R9: `xfer_end` returns the block to idle with `req_held` low from any state, and takes priority over `en_strobe`.
- R10: The `state_o` encoding is: 0 idle, 1 accepting, 2 request held, 3 waiting for high, 4 waiting for cycle end.
- R11: `en_strobe` has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_strobe | input | 1 | One-cycle pulse at the end of the channel-enabling write |
| edge_mode | input | 1 | 1 selects falling-edge activation, 0 selects level activation |
| dreq_n | input | 1 | Asynchronous active-low request pin |
| activate | input | 1 | Controller has started the transfer; clears the held request |
| cycle_end | input | 1 | Current single transfer cycle has completed |
| xfer_end | input | 1 | Whole transfer finished; forces idle |
| req_held | output | 1 | A request is pending for the controller |
| accepting | output | 1 | The block is watching for a new request |
| state_o | output | 3 | Current state code (see R10) |

## Verification
The bench builds the block with SYNC_STAGES=2 and MIN_CLEAR=2. With these values every latency is a short fixed count: three edges from pin to request, and two non-accepting cycles after activation. The floor of 2 can be made the only thing holding acceptance back: a cycle end that arrives one edge after activation, with the pin already high, must still see one extra waiting cycle in state 4. With a floor of 1 that case would not be visible.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACCEPT   = 3'd1,
        ST_HELD     = 3'd2,
        ST_WAIT_HI  = 3'd3,
        ST_WAIT_END = 3'd4
    } acc_state_e;

    typedef struct packed {
        acc_state_e state;
        logic       hi_seen;
        logic       end_seen;
    } acc_regs_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    // Resets to the inactive (high) level of the active-low pin.
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = pin_async;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], pin_async};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign pin_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dma_req_clr_timer.sv
module dma_req_clr_timer #(
    parameter int MIN_CLEAR = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    output logic floor_met
);
    localparam int W = $clog2(MIN_CLEAR + 1);
    localparam logic [W-1:0] SAT = W'(MIN_CLEAR);
    localparam logic [W-1:0] THR = W'(MIN_CLEAR - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_wait)           cnt_d = '0;
        else if (cnt_q != SAT)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign floor_met = (cnt_q >= THR);
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
    import dma_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_strobe,
    input  logic       edge_mode,
    input  logic       pin_lvl,
    input  logic       activate,
    input  logic       cycle_end,
    input  logic       xfer_end,
    input  logic       floor_met,
    output logic       in_wait,
    output logic       req_held,
    output logic       accepting,
    output logic [2:0] state_o
);
    acc_regs_t r_d, r_q;
    logic      hi_now, end_now;

    always_comb begin
        r_d     = r_q;
        hi_now  = r_q.hi_seen | pin_lvl;
        end_now = r_q.end_seen | cycle_end;
        if (xfer_end) begin
            r_d.state    = ST_IDLE;
            r_d.hi_seen  = 1'b0;
            r_d.end_seen = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (en_strobe) r_d.state = ST_ACCEPT;
                end
                ST_ACCEPT: begin
                    if (!pin_lvl) r_d.state = ST_HELD;
                end
                ST_HELD: begin
                    if (activate) begin
                        r_d.hi_seen  = ~edge_mode;
                        r_d.end_seen = 1'b0;
                        r_d.state    = edge_mode ? ST_WAIT_HI : ST_WAIT_END;
                    end
                end
                ST_WAIT_HI, ST_WAIT_END: begin
                    if (hi_now && end_now && floor_met) begin
                        r_d.state    = ST_ACCEPT;
                        r_d.hi_seen  = 1'b0;
                        r_d.end_seen = 1'b0;
                    end else begin
                        r_d.state    = hi_now ? ST_WAIT_END : ST_WAIT_HI;
                        r_d.hi_seen  = hi_now;
                        r_d.end_seen = end_now;
                    end
                end
                default: begin
                    r_d.state    = ST_IDLE;
                    r_d.hi_seen  = 1'b0;
                    r_d.end_seen = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.hi_seen  <= 1'b0;
            r_q.end_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_wait   = (r_q.state == ST_WAIT_HI) || (r_q.state == ST_WAIT_END);
    assign req_held  = (r_q.state == ST_HELD);
    assign accepting = (r_q.state == ST_ACCEPT);
    assign state_o   = r_q.state;
endmodule

// File: rtl/dma_req_accept.sv
module dma_req_accept #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CLEAR   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_strobe,
    input  logic       edge_mode,
    input  logic       dreq_n,
    input  logic       activate,
    input  logic       cycle_end,
    input  logic       xfer_end,
    output logic       req_held,
    output logic       accepting,
    output logic [2:0] state_o
);
    logic pin_lvl;
    logic in_wait;
    logic floor_met;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (dreq_n),
        .pin_sync  (pin_lvl)
    );

    dma_req_clr_timer #(.MIN_CLEAR(MIN_CLEAR)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_wait   (in_wait),
        .floor_met (floor_met)
    );

    dma_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_strobe (en_strobe),
        .edge_mode (edge_mode),
        .pin_lvl   (pin_lvl),
        .activate  (activate),
        .cycle_end (cycle_end),
        .xfer_end  (xfer_end),
        .floor_met (floor_met),
        .in_wait   (in_wait),
        .req_held  (req_held),
        .accepting (accepting),
        .state_o   (state_o)
    );
endmodule

// File: rtl/dma_req_accept_chk.sv
module dma_req_accept_chk
    import dma_req_pkg::*;
#(
    parameter int MIN_CLEAR = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_strobe,
    input logic       activate,
    input logic       xfer_end,
    input logic       req_held,
    input logic       accepting,
    input logic [2:0] state_o
);
    localparam int CW = $clog2(MIN_CLEAR + 2);
    localparam logic [CW-1:0] CSAT = CW'(MIN_CLEAR);

    logic          cur_wait;
    logic [CW-1:0] wait_cnt_q;
    logic          prev_wait_q;

    assign cur_wait = (state_o == ST_WAIT_HI) || (state_o == ST_WAIT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt_q  <= '0;
            prev_wait_q <= 1'b0;
        end else begin
            prev_wait_q <= cur_wait;
            if (!cur_wait)             wait_cnt_q <= '0;
            else if (wait_cnt_q != CSAT) wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && !en_strobe) |=> (state_o == ST_IDLE));

    p_enable_accepts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && en_strobe && !xfer_end) |=> accepting);

    p_hold_until_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_held && !activate && !xfer_end) |=> req_held);

    p_act_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_held && activate) |=> !req_held);

    p_xfer_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> (state_o == ST_IDLE && !req_held));

    p_clear_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(accepting) && prev_wait_q) |-> (wait_cnt_q >= CW'(MIN_CLEAR)));

    p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);
endmodule

bind dma_req_accept dma_req_accept_chk #(.MIN_CLEAR(MIN_CLEAR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_strobe (en_strobe),
    .activate  (activate),
    .xfer_end  (xfer_end),
    .req_held  (req_held),
    .accepting (accepting),
    .state_o   (state_o)
);

// File: tb/sim_dma_req_accept.sv
`timescale 1ns/1ps
module sim_dma_req_accept;
    localparam int SYNC_STAGES = 2;
    localparam int MIN_CLEAR   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_strobe = 1'b0;
    logic       edge_mode = 1'b1;
    logic       dreq_n = 1'b1;
    logic       activate = 1'b0;
    logic       cycle_end = 1'b0;
    logic       xfer_end = 1'b0;
    logic       req_held;
    logic       accepting;
    logic [2:0] state_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dma_req_accept #(.SYNC_STAGES(SYNC_STAGES), .MIN_CLEAR(MIN_CLEAR)) u0 (
        .clk(clk), .rst_n(rst_n), .en_strobe(en_strobe), .edge_mode(edge_mode),
        .dreq_n(dreq_n), .activate(activate), .cycle_end(cycle_end),
        .xfer_end(xfer_end), .req_held(req_held), .accepting(accepting),
        .state_o(state_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_en();   en_strobe = 1'b1; cyc(1); en_strobe = 1'b0; endtask
    task automatic pulse_act();  activate  = 1'b1; cyc(1); activate  = 1'b0; endtask
    task automatic pulse_end();  cycle_end = 1'b1; cyc(1); cycle_end = 1'b0; endtask
    task automatic pulse_xend(); xfer_end  = 1'b1; cyc(1); xfer_end  = 1'b0; endtask

    task automatic t_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset held", req_held, 0);
        dreq_n = 1'b0; cyc(5);
        chk("R1 pin ignored in idle", state_o, 0);
        chk("R1 no request in idle", req_held, 0);
        dreq_n = 1'b1; cyc(3);
    endtask

    task automatic t_enable();
        pulse_en();
        chk("R1 enable accepts", accepting, 1);
        chk("R10 accept code", state_o, 1);
    endtask

    task automatic t_edge_basic();
        edge_mode = 1'b1;
        dreq_n = 1'b0; cyc(2);
        chk("R2 still accepting during sync", state_o, 1);
        cyc(1);
        chk("R2 request held", req_held, 1);
        chk("R10 held code", state_o, 2);
        cyc(4);
        chk("R3 held until activation", req_held, 1);
        pulse_en();
        chk("R11 enable ignored when held", state_o, 2);
        pulse_act();
        chk("R3 activation clears", req_held, 0);
        chk("R4 waiting for high", state_o, 3);
        pulse_end();
        chk("R6 end before high keeps waiting", state_o, 3);
        cyc(4);
        chk("R4 low pin blocks acceptance", accepting, 0);
        dreq_n = 1'b1; cyc(2);
        chk("R6 high not yet synchronized", state_o, 3);
        cyc(1);
        chk("R6 high re-arms", state_o, 1);
        cyc(3);
        chk("R4 high pin raises nothing", req_held, 0);
    endtask

    task automatic t_min_clear();
        dreq_n = 1'b0; cyc(3);
        chk("R2 second request", state_o, 2);
        dreq_n = 1'b1; cyc(3);
        pulse_act();
        chk("R7 not accepting after activation", accepting, 0);
        pulse_end();
        chk("R7 floor holds in state 4", state_o, 4);
        chk("R7 not accepting second cycle", accepting, 0);
        cyc(1);
        chk("R7 accepts after floor", accepting, 1);
    endtask

    task automatic t_wait_end();
        dreq_n = 1'b0; cyc(3);
        dreq_n = 1'b1;
        pulse_act();
        cyc(4);
        chk("R5 high seen, waiting for end", state_o, 4);
        pulse_end();
        chk("R5 cycle end re-arms", state_o, 1);
    endtask

    task automatic t_level();
        edge_mode = 1'b0;
        dreq_n = 1'b0; cyc(3);
        chk("R8 level request", state_o, 2);
        pulse_act();
        chk("R8 skip high wait", state_o, 4);
        pulse_end();
        chk("R8 floor still pending", state_o, 4);
        cyc(1);
        chk("R8 accepts with pin low", state_o, 1);
        cyc(1);
        chk("R8 low level re-requests", req_held, 1);
    endtask

    task automatic t_xfer_end();
        pulse_xend();
        chk("R9 end from held", state_o, 0);
        chk("R9 request cleared", req_held, 0);
        cyc(3);
        chk("R9 stays idle with pin low", state_o, 0);
        en_strobe = 1'b1; xfer_end = 1'b1; cyc(1);
        en_strobe = 1'b0; xfer_end = 1'b0;
        chk("R9 end beats enable", state_o, 0);
        edge_mode = 1'b1;
        pulse_en(); cyc(1);
        chk("R2 request after re-enable", req_held, 1);
        pulse_act();
        chk("R4 waiting before end", state_o, 3);
        pulse_xend();
        chk("R9 end from wait", state_o, 0);
        dreq_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_enable();
        t_edge_basic();
        t_min_clear();
        t_wait_end();
        t_level();
        t_xfer_end();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule